// File: doc/BRIEF.md
# Interrupt Event Acceptor

This block decides, at each instruction boundary, which pending event the processor services next. It handles four sources: a software interrupt that the current instruction raises with an immediate vector, a non-maskable request pin, a coprocessor-error request and a maskable request pin. The interrupt-enable flag from the flag word gates only the maskable pin. The other three sources pass regardless of it.

For the fixed-vector sources the decision is final at once. A one-cycle take strobe follows on the next clock, with the vector and an external-origin flag. The fault error-code logic uses that flag. A maskable request is different: the block first runs an acknowledge bus sequence of two pulses. It latches the vector that the external controller drives during the second pulse. Only after that does it raise the take strobe.

The non-maskable pin is edge-triggered. A rising edge is remembered until that event is taken, so a short pulse between boundaries is not lost. The maskable pin is read as a level.

Top module: `intr_accept`

## Requirements
- R1: After reset, `take_o` and `ack_o` are low, and no non-maskable event is pending.
- R2: A high `intr_i` at a boundary with `ien_i` = 1 and no higher source starts the acknowledge sequence. With `ien_i` = 0 it is ignored: `ack_o` and `take_o` stay low.
- R3: A rising edge on `nmi_i` is held pending until taken. It is taken at the next boundary without a software request, with vector `NMI_VEC` (default 2) and `ext_o` = 1. A level held high yields only one take.
- R4: A software request (`swi_req_i`) at a boundary is taken whatever `ien_i` is. It gives vector `swi_vec_i` and `ext_o` = 0.
- R5: A coprocessor-error request (`cperr_req_i`) is taken whatever `ien_i` is. It gives vector `CPERR_VEC` (default 16) and `ext_o` = 1.
- R6: At one boundary only the highest-priority source is served. The order is software first, then non-maskable, then coprocessor error, then maskable. The others stay for later boundaries.
- R7: The acknowledge sequence drives `ack_o` high for `ACK_PULSE_W` cycles, then low for `ACK_GAP_W` cycles, then high again for `ACK_PULSE_W` cycles. `ack_data_i` is captured in the last cycle of the second pulse.
- R8: `take_o` is a one-cycle strobe. For a fixed-vector source it rises in the cycle after the boundary decision. For a maskable request it rises in the cycle after the last acknowledge cycle. `vec_o` and `ext_o` are valid while it is high.
- R9: With `boundary_i` low, or while an acknowledge sequence runs, no request is evaluated. `take_o` and `ack_o` stay low, except for the sequence's own pulses and final take.
- R10: A take that follows an acknowledge sequence carries the captured vector and `ext_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary; requests are sampled only when high |
| intr_i | input | 1 | Maskable request pin, level-sensitive |
| nmi_i | input | 1 | Non-maskable request pin, rising-edge triggered |
| ien_i | input | 1 | Interrupt-enable flag; gates only `intr_i` |
| swi_req_i | input | 1 | Software interrupt request from the current instruction |
| swi_vec_i | input | VEC_W | Immediate vector of the software interrupt |
| cperr_req_i | input | 1 | Coprocessor-error request |
| ack_data_i | input | VEC_W | Vector driven by the external controller during acknowledge |
| ack_o | output | 1 | Acknowledge pulse output |
| take_o | output | 1 | One-cycle strobe: an event is taken |
| vec_o | output | VEC_W | Vector of the taken event |
| ext_o | output | 1 | Taken event originated outside the program |

## Verification
The bench builds the block with `ACK_PULSE_W` = 2 and `ACK_GAP_W` = 3, and leaves `VEC_W` at 8. Pulses longer than one cycle exercise the counter reload on every phase change. An uneven gap makes any swapped or off-by-one phase length show up as a misplaced `ack_o` edge. Different widths for the pulse and the gap also exercise the shared counter sizing. With the long sequence, boundaries and software requests can fall inside it, which makes the ignore-while-busy rule observable.

// File: rtl/intr_pkg.sv
package intr_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_PULSE_A,
      SEQ_GAP,
      SEQ_PULSE_B
   } seq_state_t;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_SOFT,
      SRC_NMI,
      SRC_CPERR,
      SRC_MASK
   } src_t;

   localparam int unsigned SRC_COUNT = 4;

   function automatic src_t src_of_index(input int unsigned idx);
      case (idx)
         0:       return SRC_SOFT;
         1:       return SRC_NMI;
         2:       return SRC_CPERR;
         3:       return SRC_MASK;
         default: return SRC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/nmi_catch.sv
module nmi_catch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise = pin_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_i;
         pend_q <= (pend_q & ~clr_i) | rise;
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/evt_pick.sv
module evt_pick
   import intr_pkg::*;
(
   input  logic sample_i,
   input  logic soft_i,
   input  logic nmi_pend_i,
   input  logic cperr_i,
   input  logic mask_i,
   input  logic ien_i,
   output src_t src_o
);
   logic [SRC_COUNT-1:0] req;
   logic [SRC_COUNT-1:0] grant;

   assign req = {mask_i & ien_i, cperr_i, nmi_pend_i, soft_i};

   generate
      for (genvar g = 0; g < SRC_COUNT; g++) begin : g_prio
         if (g == 0) begin : g_top
            assign grant[g] = sample_i & req[g];
         end else begin : g_lower
            assign grant[g] = sample_i & req[g] & ~|req[g-1:0];
         end
      end
   endgenerate

   always_comb begin
      src_o = SRC_NONE;
      for (int unsigned i = 0; i < SRC_COUNT; i++) begin
         if (grant[i]) src_o = src_of_index(i);
      end
   end
endmodule

// File: rtl/ack_seq.sv
module ack_seq
   import intr_pkg::*;
#(
   parameter int unsigned PULSE_W = 2,
   parameter int unsigned GAP_W   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic ack_o,
   output logic busy_o,
   output logic last_o
);
   localparam int unsigned SPAN  = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
   localparam int unsigned CNT_W = $clog2(SPAN + 1);
   localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_W - 1);
   localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_W - 1);

   seq_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  st_q  <= SEQ_PULSE_A;
                  cnt_q <= PULSE_LD;
               end
            end
            SEQ_PULSE_A: begin
               if (cnt_zero) begin
                  st_q  <= SEQ_GAP;
                  cnt_q <= GAP_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SEQ_GAP: begin
               if (cnt_zero) begin
                  st_q  <= SEQ_PULSE_B;
                  cnt_q <= PULSE_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SEQ_PULSE_B: begin
               if (cnt_zero) begin
                  st_q <= SEQ_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign ack_o  = (st_q == SEQ_PULSE_A) || (st_q == SEQ_PULSE_B);
   assign busy_o = (st_q != SEQ_IDLE);
   assign last_o = (st_q == SEQ_PULSE_B) && cnt_zero;
endmodule

// File: rtl/intr_accept.sv
module intr_accept
   import intr_pkg::*;
#(
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned NMI_VEC     = 2,
   parameter int unsigned CPERR_VEC   = 16,
   parameter int unsigned ACK_PULSE_W = 1,
   parameter int unsigned ACK_GAP_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary_i,
   input  logic             intr_i,
   input  logic             nmi_i,
   input  logic             ien_i,
   input  logic             swi_req_i,
   input  logic [VEC_W-1:0] swi_vec_i,
   input  logic             cperr_req_i,
   input  logic [VEC_W-1:0] ack_data_i,
   output logic             ack_o,
   output logic             take_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             ext_o
);
   localparam logic [VEC_W-1:0] NMI_CODE   = VEC_W'(NMI_VEC);
   localparam logic [VEC_W-1:0] CPERR_CODE = VEC_W'(CPERR_VEC);

   generate
      if (VEC_W < 1)                  begin : g_bad_w   $error("VEC_W must be positive");            end
      if (NMI_VEC >= (1 << VEC_W))    begin : g_bad_nmi $error("NMI_VEC does not fit VEC_W");        end
      if (CPERR_VEC >= (1 << VEC_W))  begin : g_bad_cpe $error("CPERR_VEC does not fit VEC_W");      end
      if (ACK_PULSE_W < 1)            begin : g_bad_p   $error("ACK_PULSE_W must be at least 1");    end
      if (ACK_GAP_W < 1)              begin : g_bad_g   $error("ACK_GAP_W must be at least 1");      end
   endgenerate

   logic seq_busy;
   logic seq_last;
   logic nmi_pend;
   logic sample;
   src_t pick;

   assign sample = boundary_i & ~seq_busy;

   nmi_catch u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (nmi_i),
      .clr_i  (pick == SRC_NMI),
      .pend_o (nmi_pend)
   );

   evt_pick u_pick (
      .sample_i   (sample),
      .soft_i     (swi_req_i),
      .nmi_pend_i (nmi_pend),
      .cperr_i    (cperr_req_i),
      .mask_i     (intr_i),
      .ien_i      (ien_i),
      .src_o      (pick)
   );

   ack_seq #(
      .PULSE_W (ACK_PULSE_W),
      .GAP_W   (ACK_GAP_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (pick == SRC_MASK),
      .ack_o   (ack_o),
      .busy_o  (seq_busy),
      .last_o  (seq_last)
   );

   logic             take_q;
   logic [VEC_W-1:0] vec_q;
   logic             ext_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
         ext_q  <= 1'b0;
      end else begin
         take_q <= 1'b0;
         if (seq_last) begin
            take_q <= 1'b1;
            vec_q  <= ack_data_i;
            ext_q  <= 1'b1;
         end else begin
            case (pick)
               SRC_SOFT: begin
                  take_q <= 1'b1;
                  vec_q  <= swi_vec_i;
                  ext_q  <= 1'b0;
               end
               SRC_NMI: begin
                  take_q <= 1'b1;
                  vec_q  <= NMI_CODE;
                  ext_q  <= 1'b1;
               end
               SRC_CPERR: begin
                  take_q <= 1'b1;
                  vec_q  <= CPERR_CODE;
                  ext_q  <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign take_o = take_q;
   assign vec_o  = vec_q;
   assign ext_o  = ext_q;
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned NMI_VEC   = 2,
   parameter int unsigned CPERR_VEC = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             boundary_i,
   input logic             intr_i,
   input logic             ien_i,
   input logic             swi_req_i,
   input logic [VEC_W-1:0] swi_vec_i,
   input logic             cperr_req_i,
   input logic [VEC_W-1:0] ack_data_i,
   input logic             ack_o,
   input logic             take_o,
   input logic [VEC_W-1:0] vec_o,
   input logic             ext_o,
   input logic             busy,
   input logic             nmi_pend
);
   localparam logic [VEC_W-1:0] NMI_CODE   = VEC_W'(NMI_VEC);
   localparam logic [VEC_W-1:0] CPERR_CODE = VEC_W'(CPERR_VEC);

   // R2: masked request leaves the outputs quiet
   a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !busy && !swi_req_i && !nmi_pend && !cperr_req_i && intr_i && !ien_i)
      |=> (!ack_o && !take_o));

   // R3: pending non-maskable event gives its fixed vector
   a_r3_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !busy && !swi_req_i && nmi_pend)
      |=> (take_o && vec_o == NMI_CODE && ext_o));

   // R4: software request taken with its immediate vector
   a_r4_soft_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !busy && swi_req_i)
      |=> (take_o && vec_o == $past(swi_vec_i) && !ext_o));

   // R5: coprocessor error taken regardless of the enable flag
   a_r5_cperr_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !busy && !swi_req_i && !nmi_pend && cperr_req_i)
      |=> (take_o && vec_o == CPERR_CODE && ext_o));

   // R7 and R10: end of the second pulse delivers the captured vector
   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ack_o) && !busy) |-> (take_o && ext_o && vec_o == $past(ack_data_i)));

   // R9: nothing happens without a boundary while idle
   a_r9_no_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (!boundary_i && !busy) |=> (!take_o && !ack_o));
endmodule

bind intr_accept intr_accept_chk #(
   .VEC_W     (VEC_W),
   .NMI_VEC   (NMI_VEC),
   .CPERR_VEC (CPERR_VEC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .boundary_i  (boundary_i),
   .intr_i      (intr_i),
   .ien_i       (ien_i),
   .swi_req_i   (swi_req_i),
   .swi_vec_i   (swi_vec_i),
   .cperr_req_i (cperr_req_i),
   .ack_data_i  (ack_data_i),
   .ack_o       (ack_o),
   .take_o      (take_o),
   .vec_o       (vec_o),
   .ext_o       (ext_o),
   .busy        (seq_busy),
   .nmi_pend    (nmi_pend)
);

// File: tb/intr_accept_test.sv
`timescale 1ns/1ps
module intr_accept_test;
   localparam int P = 2;
   localparam int G = 3;
   localparam int L = 2 * P + G;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boundary = 1'b0, intr = 1'b0, nmi = 1'b0, ien = 1'b0;
   logic       swi = 1'b0, cperr = 1'b0;
   logic [7:0] swi_vec = 8'h00, ack_data = 8'h00;
   logic       ack_o, take_o, ext_o;
   logic [7:0] vec_o;

   always #2 clk = ~clk;

   intr_accept #(.VEC_W(8), .ACK_PULSE_W(P), .ACK_GAP_W(G)) uut (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .intr_i(intr), .nmi_i(nmi),
      .ien_i(ien), .swi_req_i(swi), .swi_vec_i(swi_vec), .cperr_req_i(cperr),
      .ack_data_i(ack_data), .ack_o(ack_o), .take_o(take_o), .vec_o(vec_o), .ext_o(ext_o));

   int    n_cmp = 0, n_bad = 0;
   string phase_tag = "R1";

   // behavioural reference
   int    m_pos = 0;
   bit    m_pend = 0, m_prev = 0;
   bit    exp_take = 0, exp_ext = 0, exp_ack = 0;
   int    exp_vec = 0;
   string m_tag = "R1";

   always @(posedge clk) begin
      bit rise;
      if (!rst_n) begin
         m_pos = 0; m_pend = 0; m_prev = 0;
         exp_take = 0; exp_ack = 0;
      end else begin
         rise = nmi && !m_prev;
         exp_take = 0;
         if (m_pos > 0) begin
            if (m_pos == L) begin
               exp_take = 1; exp_vec = ack_data; exp_ext = 1; m_tag = "R10"; m_pos = 0;
            end else m_pos++;
         end else if (boundary) begin
            if (swi) begin
               exp_take = 1; exp_vec = swi_vec; exp_ext = 0; m_tag = "R4";
            end else if (m_pend) begin
               exp_take = 1; exp_vec = 2; exp_ext = 1; m_tag = "R3"; m_pend = 0;
            end else if (cperr) begin
               exp_take = 1; exp_vec = 16; exp_ext = 1; m_tag = "R5";
            end else if (intr && ien) begin
               m_pos = 1;
            end
         end
         if (rise) m_pend = 1;
         m_prev = nmi;
         exp_ack = (m_pos >= 1 && m_pos <= P) || (m_pos > P + G);
      end
   end

   task automatic check(input string tag, input int act, input int exp, input string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      check("R7", ack_o, exp_ack, "ack_o");
      check(exp_take ? "R8" : phase_tag, take_o, exp_take, "take_o");
      if (exp_take) begin
         check(m_tag, vec_o, exp_vec, "vec_o");
         check(m_tag, ext_o, exp_ext, "ext_o");
      end
   end

   task automatic cyc(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   bit finished = 0;
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      phase_tag = "R1";
      cyc(3);
      check("R1", take_o, 0, "take_o in reset");
      check("R1", ack_o, 0, "ack_o in reset");
      rst_n = 1'b1;
      cyc(2);

      phase_tag = "R2";                // masked request is ignored
      intr = 1; ien = 0; boundary = 1; cyc(6);
      ien = 1; ack_data = 8'h41; cyc(1);
      boundary = 0; cyc(L + 3);
      intr = 0; ien = 0;

      phase_tag = "R4";                // software request with flag clear
      swi = 1; swi_vec = 8'h80; boundary = 1; cyc(1);
      swi = 0; boundary = 0; cyc(2);

      phase_tag = "R3";                // held level yields one take
      nmi = 1; cyc(2); boundary = 1; cyc(4);
      nmi = 0; boundary = 0; cyc(2);

      phase_tag = "R5";
      cperr = 1; boundary = 1; cyc(1);
      cperr = 0; boundary = 0; cyc(2);

      phase_tag = "R6";                // all sources together
      nmi = 1; cyc(1); nmi = 0;
      swi = 1; swi_vec = 8'h21; cperr = 1; intr = 1; ien = 1; ack_data = 8'h99;
      boundary = 1; cyc(1);
      swi = 0; cyc(1);
      cyc(1); cperr = 0;
      cyc(2);
      phase_tag = "R9";                // requests inside the sequence are ignored
      swi = 1; swi_vec = 8'h33; cyc(2); swi = 0; intr = 0; cyc(L);
      boundary = 0; swi = 1; cperr = 1; intr = 1; cyc(5);
      swi = 0; cperr = 0; intr = 0; ien = 0; cyc(2);

      phase_tag = "R6";
      for (int i = 0; i < 4000; i++) begin
         boundary = ($urandom % 3) != 0;
         intr     = ($urandom % 2) != 0;
         ien      = ($urandom % 3) != 0;
         nmi      = ($urandom % 6) == 0;
         swi      = ($urandom % 9) == 0;
         cperr    = ($urandom % 11) == 0;
         swi_vec  = 8'($urandom);
         ack_data = 8'($urandom);
         cyc(1);
      end
      boundary = 0; swi = 0; cperr = 0; intr = 0; nmi = 0;
      cyc(L + 2);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule